// File: doc/BRIEF.md
# Bidirectional Registered Bus Transceiver

This block joins two 18-bit data ports, called A and B, with one storage path for each direction of transfer. Each path has its own storage stage, and that stage works in one of three ways. In transparent mode the path passes its input through to the far side. In hold mode it keeps its stored word. In clocked mode it captures its input when a rising edge of that direction's transfer strobe arrives and the strobe enable is asserted. Each direction has a transparency control, a transfer strobe, an active-low strobe enable and an output enable. The A-to-B output enable is active high. The B-to-A output enable is active low.

The block runs on the core clock. Each transfer strobe is sampled on the core clock, and a rising edge is a core-clock cycle in which the sampled strobe is high after being low in the previous cycle. Each driven side is a tri-state output, shown at the ports as a data bus plus a drive-enable bit. A disabled side drives its enable bit low and its data bus to zero. The other side of the bus is then free to drive.

Top module: `univ_bus_xcvr`

## Requirements
- R1: After reset both storage stages hold zero. With transparency off and the outputs enabled, `b_out` and `a_out` read zero.
- R2: While `ab_pass` is 1 and `ab_oe` is 1, `b_out` equals `a_in` in the same cycle, with no register on the path.
- R3: While `ab_pass` is 0 and `ab_stb_en_n` is 0, a rising edge of `ab_stb` (sampled high at a core-clock edge after being sampled low at the previous edge) stores `a_in` at that core-clock edge. `b_out` shows the stored word from that edge on.
- R4: While `ab_stb_en_n` is 1, rising edges of `ab_stb` store nothing, and `b_out` keeps its value.
- R5: While `ab_pass` is 0 and no qualifying strobe edge occurs, `b_out` keeps its value whatever `a_in` does.
- R6: While `ab_pass` is 1, `ab_stb` is 1 and the strobe enable is asserted, the stage reloads `a_in` at every core-clock edge. When `ab_pass` falls, the word held is the `a_in` of the last such edge. If `ab_stb` stayed 0 during transparency, the word held is the one from the last clocked capture.
- R7: `ab_oe` = 0 drives `b_drive` to 0 and `b_out` to zero. `ab_oe` = 1 drives `b_drive` to 1.
- R8: The B-to-A path behaves like R2 to R6, using `ba_pass`, `ba_stb` and `ba_stb_en_n`, with `b_in` as its source and `a_out` as its output. `ba_oe_n` = 1 drives `a_drive` and `a_out` to 0, and `ba_oe_n` = 0 drives `a_drive` to 1.
- R9: The controls and input of one direction have no effect on the stored word or the output of the other direction.
- R10: A strobe held high across many core-clock cycles gives a single capture. A new capture needs the strobe to go low and then high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| a_in | input | 18 | Word received on side A |
| b_in | input | 18 | Word received on side B |
| ab_pass | input | 1 | A-to-B transparency, active high |
| ab_stb | input | 1 | A-to-B transfer strobe |
| ab_stb_en_n | input | 1 | A-to-B strobe enable, active low |
| ab_oe | input | 1 | Side B output enable, active high |
| ba_pass | input | 1 | B-to-A transparency, active high |
| ba_stb | input | 1 | B-to-A transfer strobe |
| ba_stb_en_n | input | 1 | B-to-A strobe enable, active low |
| ba_oe_n | input | 1 | Side A output enable, active low |
| b_out | output | 18 | Word driven on side B |
| b_drive | output | 1 | Side B drive enable (0 means high impedance) |
| a_out | output | 18 | Word driven on side A |
| a_drive | output | 1 | Side A drive enable (0 means high impedance) |

## Verification
Three kinds of result have different timing. Transparency and output-enable results are combinational and appear in the same cycle as the stimulus. A strobe capture appears one core-clock edge after the strobe is first seen high. A held word must stay unchanged across every later edge. The bench drives all inputs on the falling edge. It checks combinational results a moment after driving them, and it checks stored results on the falling edge that follows the capturing rising edge. For a hold, it changes the input, lets one or more full cycles pass, and then compares the output with the earlier word.

// File: rtl/bt_pkg.sv
package bt_pkg;
   localparam int unsigned DIRS = 2;
   localparam int unsigned DIR_AB = 0;
   localparam int unsigned DIR_BA = 1;

   typedef struct packed {
      logic pass;
      logic stb;
      logic stb_en_n;
   } bt_ctl_t;
endpackage

// File: rtl/bt_edge_det.sv
module bt_edge_det #(
   parameter int unsigned SYNC_STAGES = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic strobe_i,
   output logic level_o,
   output logic rise_o
);
   logic prev_q;

   if (SYNC_STAGES > 4) begin : g_bad_sync
      $error("bt_edge_det: SYNC_STAGES above 4 not supported");
   end

   if (SYNC_STAGES == 0) begin : g_direct
      assign level_o = strobe_i;
   end else begin : g_sync
      logic [SYNC_STAGES-1:0] sync_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sync_q <= '1;
         else        sync_q <= {sync_q[SYNC_STAGES-1:0], strobe_i} >> 0;
      end
      assign level_o = sync_q[SYNC_STAGES-1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b1;
      else        prev_q <= level_o;
   end

   assign rise_o = level_o & ~prev_q;

   // R10
   single_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o |=> !rise_o);
endmodule

// File: rtl/bt_store_lane.sv
module bt_store_lane #(
   parameter int unsigned WIDTH = 18
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   input  logic             pass_i,
   input  logic             level_i,
   input  logic             rise_i,
   input  logic             stb_en_n_i,
   output logic [WIDTH-1:0] q_o
);
   logic [WIDTH-1:0] store_q;
   logic             load;

   if (WIDTH < 1) begin : g_bad_width
      $error("bt_store_lane: WIDTH must be at least 1");
   end

   assign load = ~stb_en_n_i & (pass_i ? level_i : rise_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    store_q <= '0;
      else if (load) store_q <= d_i;
   end

   assign q_o = pass_i ? d_i : store_q;

   // R3
   edge_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!pass_i && rise_i && !stb_en_n_i) |=> (q_o == $past(d_i) || pass_i));

   // R5
   hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!pass_i && !(rise_i && !stb_en_n_i)) |=> $stable(store_q));

   // R4
   gated_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stb_en_n_i |=> $stable(store_q));
endmodule

// File: rtl/bt_drive.sv
module bt_drive #(
   parameter int unsigned WIDTH         = 18,
   parameter bit          OE_ACTIVE_LOW = 1'b0
) (
   input  logic             oe_i,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] data_o,
   output logic             drive_o
);
   logic active;

   if (OE_ACTIVE_LOW) begin : g_oe_low
      assign active = ~oe_i;
   end else begin : g_oe_high
      assign active = oe_i;
   end

   assign drive_o = active;
   assign data_o  = active ? d_i : '0;
endmodule

// File: rtl/univ_bus_xcvr.sv
module univ_bus_xcvr
   import bt_pkg::*;
#(
   parameter int unsigned WIDTH       = 18,
   parameter int unsigned SYNC_STAGES = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] a_in,
   input  logic [WIDTH-1:0] b_in,
   input  logic             ab_pass,
   input  logic             ab_stb,
   input  logic             ab_stb_en_n,
   input  logic             ab_oe,
   input  logic             ba_pass,
   input  logic             ba_stb,
   input  logic             ba_stb_en_n,
   input  logic             ba_oe_n,
   output logic [WIDTH-1:0] b_out,
   output logic             b_drive,
   output logic [WIDTH-1:0] a_out,
   output logic             a_drive
);
   bt_ctl_t          ctl  [DIRS];
   logic [WIDTH-1:0] din  [DIRS];
   logic [WIDTH-1:0] held [DIRS];

   assign ctl[DIR_AB] = '{pass: ab_pass, stb: ab_stb, stb_en_n: ab_stb_en_n};
   assign ctl[DIR_BA] = '{pass: ba_pass, stb: ba_stb, stb_en_n: ba_stb_en_n};
   assign din[DIR_AB] = a_in;
   assign din[DIR_BA] = b_in;

   for (genvar g = 0; g < DIRS; g++) begin : g_dir
      logic lvl, rise;

      bt_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
         .clk      (clk),
         .rst_n    (rst_n),
         .strobe_i (ctl[g].stb),
         .level_o  (lvl),
         .rise_o   (rise)
      );

      bt_store_lane #(.WIDTH(WIDTH)) u_lane (
         .clk        (clk),
         .rst_n      (rst_n),
         .d_i        (din[g]),
         .pass_i     (ctl[g].pass),
         .level_i    (lvl),
         .rise_i     (rise),
         .stb_en_n_i (ctl[g].stb_en_n),
         .q_o        (held[g])
      );
   end

   bt_drive #(.WIDTH(WIDTH), .OE_ACTIVE_LOW(1'b0)) u_drv_b (
      .oe_i    (ab_oe),
      .d_i     (held[DIR_AB]),
      .data_o  (b_out),
      .drive_o (b_drive)
   );

   bt_drive #(.WIDTH(WIDTH), .OE_ACTIVE_LOW(1'b1)) u_drv_a (
      .oe_i    (ba_oe_n),
      .d_i     (held[DIR_BA]),
      .data_o  (a_out),
      .drive_o (a_drive)
   );

   // R2
   ab_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ab_pass && ab_oe) |-> (b_out == a_in));

   // R7
   ab_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ab_oe |-> (!b_drive && b_out == '0));

   // R8
   ba_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ba_oe_n |-> (!a_drive && a_out == '0));

   // R8
   ba_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ba_pass && !ba_oe_n) |-> (a_out == b_in));
endmodule

// File: tb/tb_univ_bus_xcvr.sv
`timescale 1ns/1ps
module tb_univ_bus_xcvr;
   localparam int W = 18;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [W-1:0] a_in = '0, b_in = '0;
   logic         ab_pass = 0, ab_stb = 0, ab_stb_en_n = 0, ab_oe = 1;
   logic         ba_pass = 0, ba_stb = 0, ba_stb_en_n = 0, ba_oe_n = 0;
   logic [W-1:0] b_out, a_out;
   logic         b_drive, a_drive;

   int total = 0;
   int bad = 0;

   always #5 clk = ~clk;

   univ_bus_xcvr #(.WIDTH(W)) dut (
      .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in),
      .ab_pass(ab_pass), .ab_stb(ab_stb), .ab_stb_en_n(ab_stb_en_n), .ab_oe(ab_oe),
      .ba_pass(ba_pass), .ba_stb(ba_stb), .ba_stb_en_n(ba_stb_en_n), .ba_oe_n(ba_oe_n),
      .b_out(b_out), .b_drive(b_drive), .a_out(a_out), .a_drive(a_drive)
   );

   task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   // dir 0 = A-to-B, dir 1 = B-to-A
   task automatic set_ctl(input bit dir, input logic pass, input logic stb, input logic en_n);
      if (dir == 0) begin ab_pass = pass; ab_stb = stb; ab_stb_en_n = en_n; end
      else          begin ba_pass = pass; ba_stb = stb; ba_stb_en_n = en_n; end
   endtask

   task automatic set_in(input bit dir, input logic [W-1:0] v);
      if (dir == 0) a_in = v; else b_in = v;
   endtask

   function automatic logic [W-1:0] out_of(input bit dir);
      return (dir == 0) ? b_out : a_out;
   endfunction

   task automatic t_reset();
      #1;
      chk("R1 b_out", b_out, '0);
      chk("R1 a_out", a_out, '0);
   endtask

   task automatic t_transparent(input bit dir, input string tag);
      set_ctl(dir, 1, 0, 0);
      set_in(dir, 18'h2A5A5); #1; chk(tag, out_of(dir), 18'h2A5A5);
      set_in(dir, 18'h15A5A); #1; chk(tag, out_of(dir), 18'h15A5A);
      tick();
   endtask

   task automatic t_clocked(input bit dir, input string tag);
      set_ctl(dir, 0, 0, 0); set_in(dir, 18'h00111); tick();
      set_ctl(dir, 0, 1, 0); set_in(dir, 18'h12345); tick();
      chk({tag, " capture"}, out_of(dir), 18'h12345);
      // R10: strobe kept high, no second capture
      set_in(dir, 18'h0BEEF); tick(); tick();
      chk({tag, " R10 level"}, out_of(dir), 18'h12345);
      set_ctl(dir, 0, 0, 0); tick();
      chk({tag, " R5 fall"}, out_of(dir), 18'h12345);
      set_ctl(dir, 0, 1, 0); tick();
      chk({tag, " recapture"}, out_of(dir), 18'h0BEEF);
      set_ctl(dir, 0, 0, 0); tick();
   endtask

   task automatic t_gate(input bit dir, input string tag);
      set_ctl(dir, 0, 0, 1); set_in(dir, 18'h3C3C3); tick();
      set_ctl(dir, 0, 1, 1); tick();
      chk(tag, out_of(dir), 18'h0BEEF);
      set_ctl(dir, 0, 0, 1); tick();
      set_ctl(dir, 0, 0, 0); tick();
   endtask

   task automatic t_hold(input bit dir, input string tag);
      set_in(dir, 18'h00F0F); tick(); tick();
      chk(tag, out_of(dir), 18'h0BEEF);
      set_in(dir, 18'h3FFFF); tick();
      chk(tag, out_of(dir), 18'h0BEEF);
   endtask

   task automatic t_close(input bit dir, input string tag);
      set_ctl(dir, 1, 1, 0); set_in(dir, 18'h1ABCD); tick();
      set_ctl(dir, 0, 1, 0); set_in(dir, 18'h02222); #1;
      chk({tag, " strobe high"}, out_of(dir), 18'h1ABCD);
      tick();
      chk({tag, " strobe high kept"}, out_of(dir), 18'h1ABCD);
      set_ctl(dir, 0, 0, 0); tick();
      set_ctl(dir, 0, 1, 0); set_in(dir, 18'h07777); tick();
      set_ctl(dir, 0, 0, 0); tick();
      set_ctl(dir, 1, 0, 0); set_in(dir, 18'h33333); tick(); #1;
      chk({tag, " transparent"}, out_of(dir), 18'h33333);
      set_ctl(dir, 0, 0, 0); #1;
      chk({tag, " strobe low"}, out_of(dir), 18'h07777);
      tick();
   endtask

   task automatic t_oe();
      ab_oe = 0; #1;
      chk("R7 b_drive off", {17'b0, b_drive}, 18'h0);
      chk("R7 b_out zero", b_out, '0);
      chk("R9 a side unaffected by ab_oe", {17'b0, a_drive}, 18'h1);
      ab_oe = 1; #1;
      chk("R7 b_drive on", {17'b0, b_drive}, 18'h1);
      ba_oe_n = 1; #1;
      chk("R8 a_drive off", {17'b0, a_drive}, 18'h0);
      chk("R8 a_out zero", a_out, '0);
      chk("R9 b side unaffected by ba_oe_n", {17'b0, b_drive}, 18'h1);
      ba_oe_n = 0; #1;
      chk("R8 a_drive on", {17'b0, a_drive}, 18'h1);
      tick();
   endtask

   task automatic t_indep(input bit dir, input string tag);
      logic [W-1:0] keep;
      keep = out_of(dir);
      for (int i = 0; i < 4; i++) begin
         set_ctl(!dir, 1, 1, 0); set_in(!dir, 18'h01000 + 18'(i)); tick();
         set_ctl(!dir, 0, 0, 0); tick();
         set_ctl(!dir, 0, 1, 0); tick();
      end
      chk(tag, out_of(dir), keep);
      set_ctl(!dir, 0, 0, 0); tick();
   endtask

   initial begin
      #2_000_000;
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      @(negedge clk); @(negedge clk);
      rst_n = 1'b1;
      tick();
      t_reset();
      t_transparent(0, "R2");
      t_transparent(1, "R8 transparent");
      t_clocked(0, "R3");
      t_clocked(1, "R8 clocked");
      t_gate(0, "R4");
      t_gate(1, "R8 gate");
      t_hold(0, "R5");
      t_hold(1, "R8 hold");
      t_indep(0, "R9 A-to-B");
      t_indep(1, "R9 B-to-A");
      t_close(0, "R6");
      t_close(1, "R8 close");
      t_oe();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule